// File: doc/BRIEF.md
# Vectored Interrupt Controller with Edge/Level Capture

This block collects up to thirty-two interrupt request lines and presents them to a processor as a single request line plus a vector. Each request line is fixed at build time as either edge-captured or level-driven. Captured requests are latched in a status register. An enable register masks the status register to give a pending set. The lowest-numbered pending line is reported as the vector.

Software reaches the block through a small word-indexed register bus. It can clear serviced requests by writing ones to an acknowledge address. It can turn individual enables on or off through dedicated set and clear addresses, with no read-modify-write. A two-bit master register gates two things: the processor request line, and whether the input pins feed the status register at all. While the pins are not feeding it, software may write the status register directly, for example to raise a software interrupt during bring-up.

Top module: `vec_irq_ctrl`

## Requirements
- R1: A synchronous active-high reset clears the status, enable and master registers. After reset, `irq_out` is low and the vector reads all ones.
- R2: Reading word index 1 (pending) returns the bitwise AND of status (index 0) and enable (index 2).
- R3: `irq_out` is high exactly when master bit 0 is set and the pending set is non-zero. It is combinational from registered state.
- R4: Reading word index 6 (vector) returns the index of the lowest-numbered set pending bit. It returns all ones when no bit is pending.
- R5: A write to word index 3 (acknowledge) clears every status bit whose written bit is 1 and leaves the other status bits unchanged.
- R6: A write to index 4 ORs the data into enable. A write to index 5 clears the enable bits written as 1. A write to index 2 replaces enable.
- R7: A write to word index 7 (master) keeps only data bits 1:0. Bit 0 gates `irq_out`, and bit 1 is the pin-capture enable. Reading index 7 returns those two bits with zeros above.
- R8: A write to index 0 loads status only while master bit 1 is 0. While master bit 1 is 1, the write is ignored.
- R9: While master bit 1 is 1, every level-kind input that is high at a clock edge sets its status bit. That bit stays set until it is acknowledged. While master bit 1 is 0, the inputs do not change status.
- R10: While master bit 1 is 1, an edge-kind input sets its status bit when it is high at a clock edge after being low at the previous edge. The bit stays set after the input falls and until it is acknowledged. Acknowledging it while the input stays high does not set it again.
- R11: Reads of indices 3, 4, 5 and of any index above 7 return 0. Writes to indices 1, 6 and any index above 7 change no state.
- R12: Read data appears on `bus_rdata` in the cycle after a read strobe and reflects the state before that edge. A capture at the same edge as an acknowledge wins.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Block clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_sel | input | 1 | Register access strobe, one cycle per access |
| bus_we | input | 1 | 1 for write, 0 for read |
| bus_addr | input | ADDR_W | Word index of the register |
| bus_wdata | input | DATA_W | Write data |
| bus_rdata | output | DATA_W | Registered read data |
| irq_in | input | NUM_SRC | Interrupt request lines, synchronous to clk |
| irq_out | output | 1 | Request to the processor |

## Verification
The bench builds the block with NUM_SRC = 32, DATA_W = 32 and an edge mask of 0x0000FF00, so that lines 8 to 15 are edge-kind and all others are level-kind. With both kinds in one build, the bench can compare sticky edge capture and repeated level capture under the same acknowledge writes. ADDR_W is raised to 4, which places word indices 8 to 15 on the bus, so the undefined-address read and write rules can be exercised. The behavioural model tracks status, enable, master and the previous input sample. It is compared against `irq_out` and every read result on each clock.

// File: rtl/vic_pkg.sv
package vic_pkg;

  // Word indices of the register bus; software depends on this map.
  typedef enum logic [2:0] {
    RIX_STATUS = 3'd0,
    RIX_PEND   = 3'd1,
    RIX_ENABLE = 3'd2,
    RIX_ACK    = 3'd3,
    RIX_SETEN  = 3'd4,
    RIX_CLREN  = 3'd5,
    RIX_VECTOR = 3'd6,
    RIX_MASTER = 3'd7
  } vic_reg_e;

  localparam int unsigned VIC_NREG = 8;

  // Master register bit positions.
  localparam int unsigned MST_OUT_BIT = 0;
  localparam int unsigned MST_HW_BIT  = 1;

endpackage

// File: rtl/vic_capture.sv
module vic_capture #(
  parameter int unsigned NUM_SRC   = 32,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [NUM_SRC-1:0] src_i,
  input  logic               arm_i,
  output logic [NUM_SRC-1:0] set_o
);

  for (genvar g = 0; g < NUM_SRC; g++) begin : g_src
    if (EDGE_MASK[g]) begin : g_edge
      logic prev_q;
      always_ff @(posedge clk) begin
        if (rst) prev_q <= 1'b0;
        else     prev_q <= src_i[g];
      end
      assign set_o[g] = arm_i & src_i[g] & ~prev_q;
    end else begin : g_level
      assign set_o[g] = arm_i & src_i[g];
    end
  end

endmodule

// File: rtl/vic_regfile.sv
module vic_regfile
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               wr_i,
  input  vic_reg_e           idx_i,
  input  logic [NUM_SRC-1:0] wdata_i,
  input  logic [1:0]         wmst_i,
  input  logic [NUM_SRC-1:0] set_i,
  output logic [NUM_SRC-1:0] status_o,
  output logic [NUM_SRC-1:0] enable_o,
  output logic [1:0]         master_o
);

  logic [NUM_SRC-1:0] status_d, enable_d;
  logic [1:0]         master_d;

  always_comb begin
    status_d = status_o;
    enable_d = enable_o;
    master_d = master_o;
    if (wr_i) begin
      unique case (idx_i)
        RIX_STATUS: if (!master_o[MST_HW_BIT]) status_d = wdata_i;
        RIX_ACK:    status_d = status_o & ~wdata_i;
        RIX_ENABLE: enable_d = wdata_i;
        RIX_SETEN:  enable_d = enable_o | wdata_i;
        RIX_CLREN:  enable_d = enable_o & ~wdata_i;
        RIX_MASTER: master_d = wmst_i;
        default:    ;
      endcase
    end
    // Hardware capture is applied last so a same-edge request survives an acknowledge.
    status_d = status_d | set_i;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_o <= '0;
      enable_o <= '0;
      master_o <= '0;
    end else begin
      status_o <= status_d;
      enable_o <= enable_d;
      master_o <= master_d;
    end
  end

endmodule

// File: rtl/vic_prio.sv
module vic_prio #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned IDX_W   = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1
) (
  input  logic [NUM_SRC-1:0] req_i,
  output logic [IDX_W-1:0]   idx_o,
  output logic               any_o
);

  always_comb begin
    idx_o = '0;
    any_o = |req_i;
    // Scan downward so the lowest set index is written last.
    for (int i = NUM_SRC - 1; i >= 0; i--) begin
      if (req_i[i]) idx_o = IDX_W'(i);
    end
  end

endmodule

// File: rtl/vec_irq_ctrl.sv
module vec_irq_ctrl
  import vic_pkg::*;
#(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 3,
  parameter logic [NUM_SRC-1:0] EDGE_MASK = '0
) (
  input  logic               clk,
  input  logic               rst,
  input  logic               bus_sel,
  input  logic               bus_we,
  input  logic [ADDR_W-1:0]  bus_addr,
  input  logic [DATA_W-1:0]  bus_wdata,
  output logic [DATA_W-1:0]  bus_rdata,
  input  logic [NUM_SRC-1:0] irq_in,
  output logic               irq_out
);

  localparam int unsigned IDX_W = (NUM_SRC > 1) ? $clog2(NUM_SRC) : 1;

  logic               in_map;
  vic_reg_e           reg_idx;
  logic               wr_hit;
  logic [NUM_SRC-1:0] cap_set, status, enable, pending;
  logic [1:0]         master;
  logic [IDX_W-1:0]   vec_idx;
  logic               vec_any;
  logic [DATA_W-1:0]  rd_mux;

  assign in_map  = (32'(bus_addr) < VIC_NREG);
  assign reg_idx = vic_reg_e'(bus_addr[2:0]);
  assign wr_hit  = bus_sel & bus_we & in_map;

  vic_capture #(
    .NUM_SRC   (NUM_SRC),
    .EDGE_MASK (EDGE_MASK)
  ) u_cap (
    .clk   (clk),
    .rst   (rst),
    .src_i (irq_in),
    .arm_i (master[MST_HW_BIT]),
    .set_o (cap_set)
  );

  vic_regfile #(
    .NUM_SRC (NUM_SRC)
  ) u_regs (
    .clk      (clk),
    .rst      (rst),
    .wr_i     (wr_hit),
    .idx_i    (reg_idx),
    .wdata_i  (bus_wdata[NUM_SRC-1:0]),
    .wmst_i   (bus_wdata[1:0]),
    .set_i    (cap_set),
    .status_o (status),
    .enable_o (enable),
    .master_o (master)
  );

  assign pending = status & enable;

  vic_prio #(
    .NUM_SRC (NUM_SRC),
    .IDX_W   (IDX_W)
  ) u_prio (
    .req_i (pending),
    .idx_o (vec_idx),
    .any_o (vec_any)
  );

  assign irq_out = master[MST_OUT_BIT] & vec_any;

  always_comb begin
    rd_mux = '0;
    if (in_map) begin
      unique case (reg_idx)
        RIX_STATUS: rd_mux = DATA_W'(status);
        RIX_PEND:   rd_mux = DATA_W'(pending);
        RIX_ENABLE: rd_mux = DATA_W'(enable);
        RIX_VECTOR: rd_mux = vec_any ? DATA_W'(vec_idx) : '1;
        RIX_MASTER: rd_mux = DATA_W'(master);
        default:    rd_mux = '0;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)                  bus_rdata <= '0;
    else if (bus_sel & !bus_we) bus_rdata <= rd_mux;
  end

endmodule

// File: rtl/vic_checker.sv
module vic_checker #(
  parameter int unsigned NUM_SRC = 32,
  parameter int unsigned DATA_W  = 32,
  parameter int unsigned ADDR_W  = 3,
  parameter int unsigned IDX_W   = 5
) (
  input logic               clk,
  input logic               rst,
  input logic               bus_sel,
  input logic               bus_we,
  input logic [ADDR_W-1:0]  bus_addr,
  input logic [DATA_W-1:0]  bus_wdata,
  input logic [DATA_W-1:0]  bus_rdata,
  input logic               irq_out,
  input logic [NUM_SRC-1:0] status,
  input logic [NUM_SRC-1:0] enable,
  input logic [1:0]         master,
  input logic [NUM_SRC-1:0] cap_set,
  input logic [IDX_W-1:0]   vec_idx,
  input logic               vec_any
);

  logic [NUM_SRC-1:0] pend_c;
  logic [NUM_SRC-1:0] wd_c;
  assign pend_c = status & enable;
  assign wd_c   = bus_wdata[NUM_SRC-1:0];

  // R1
  rst_clear_chk: assert property (@(posedge clk)
    rst |=> (status == '0 && enable == '0 && master == 2'b00));

  // R3
  irq_gate_chk: assert property (@(posedge clk) disable iff (rst)
    !master[0] |-> !irq_out);

  // R4
  vec_hit_chk: assert property (@(posedge clk) disable iff (rst)
    vec_any |-> pend_c[vec_idx]);

  // R4
  vec_lowest_chk: assert property (@(posedge clk) disable iff (rst)
    vec_any |-> ((pend_c & ~({NUM_SRC{1'b1}} << vec_idx)) == '0));

  // R5
  ack_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == ADDR_W'(3) && !master[1])
      |=> ((status & $past(wd_c)) == '0));

  // R6
  seten_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == ADDR_W'(4))
      |=> ((enable & $past(wd_c)) == $past(wd_c)));

  // R6
  clren_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == ADDR_W'(5))
      |=> ((enable & $past(wd_c)) == '0));

  // R7
  master_rd_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && !bus_we && bus_addr == ADDR_W'(7))
      |=> (bus_rdata[DATA_W-1:2] == '0));

  // R8
  status_lock_chk: assert property (@(posedge clk) disable iff (rst)
    (bus_sel && bus_we && bus_addr == ADDR_W'(0) && master[1])
      |=> ((status & ~$past(status) & ~$past(cap_set)) == '0));

  // R9 R10
  capture_set_chk: assert property (@(posedge clk) disable iff (rst)
    (|cap_set) |=> ((status & $past(cap_set)) == $past(cap_set)));

  // R9
  capture_arm_chk: assert property (@(posedge clk) disable iff (rst)
    !master[1] |-> (cap_set == '0));

endmodule

bind vec_irq_ctrl vic_checker #(
  .NUM_SRC (NUM_SRC),
  .DATA_W  (DATA_W),
  .ADDR_W  (ADDR_W),
  .IDX_W   (IDX_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .bus_sel   (bus_sel),
  .bus_we    (bus_we),
  .bus_addr  (bus_addr),
  .bus_wdata (bus_wdata),
  .bus_rdata (bus_rdata),
  .irq_out   (irq_out),
  .status    (status),
  .enable    (enable),
  .master    (master),
  .cap_set   (cap_set),
  .vec_idx   (vec_idx),
  .vec_any   (vec_any)
);

// File: tb/sim_vec_irq_ctrl.sv
module sim_vec_irq_ctrl;

  localparam int CLK_PERIOD = 10;
  localparam int NUM_SRC    = 32;
  localparam int DATA_W     = 32;
  localparam int ADDR_W     = 4;
  localparam logic [31:0] EDGE = 32'h0000_FF00;

  logic              clk = 1'b0;
  logic              rst = 1'b1;
  logic              sel = 1'b0;
  logic              we  = 1'b0;
  logic [ADDR_W-1:0] addr = '0;
  logic [31:0]       wdata = '0;
  logic [31:0]       irq_in = '0;
  logic [31:0]       rdata;
  logic              irq;

  always #(CLK_PERIOD/2) clk = ~clk;

  vec_irq_ctrl #(
    .NUM_SRC   (NUM_SRC),
    .DATA_W    (DATA_W),
    .ADDR_W    (ADDR_W),
    .EDGE_MASK (EDGE)
  ) u0 (
    .clk       (clk),
    .rst       (rst),
    .bus_sel   (sel),
    .bus_we    (we),
    .bus_addr  (addr),
    .bus_wdata (wdata),
    .bus_rdata (rdata),
    .irq_in    (irq_in),
    .irq_out   (irq)
  );

  int checks = 0;
  int errors = 0;
  bit done   = 0;

  // Behavioural reference state
  bit [31:0] m_sts, m_en, m_prev, m_rd;
  bit [1:0]  m_mst;
  bit        m_rd_due;

  function automatic bit [31:0] m_read(int a);
    bit [31:0] p;
    p = m_sts & m_en;
    case (a)
      0: return m_sts;
      1: return p;
      2: return m_en;
      6: begin
        for (int i = 0; i < 32; i++) if (p[i]) return 32'(i);
        return 32'hFFFF_FFFF;
      end
      7: return {30'd0, m_mst};
      default: return 32'd0;
    endcase
  endfunction

  always @(posedge clk) begin
    if (rst) begin
      m_sts = 0; m_en = 0; m_mst = 0; m_prev = 0; m_rd_due = 0;
    end else begin
      bit [31:0] ns;
      m_rd_due = sel && !we;
      if (m_rd_due) m_rd = m_read(int'(addr));
      ns = m_sts;
      if (sel && we) begin
        case (int'(addr))
          0: if (!m_mst[1]) ns = wdata;
          2: m_en = wdata;
          3: ns = ns & ~wdata;
          4: m_en = m_en | wdata;
          5: m_en = m_en & ~wdata;
          7: m_mst = wdata[1:0];
          default: ;
        endcase
      end
      if (m_mst[1] && !(sel && we && int'(addr) == 7)) begin
        ns = ns | (irq_in & ~EDGE) | (irq_in & ~m_prev & EDGE);
      end else if (sel && we && int'(addr) == 7 && m_read_hw_before) begin
        ns = ns | (irq_in & ~EDGE) | (irq_in & ~m_prev & EDGE);
      end
      m_prev = irq_in;
      m_sts = ns;
    end
  end

  // Capture uses the master value held before the edge; remember it across a master write.
  bit m_read_hw_before;
  always @(negedge clk) m_read_hw_before = m_mst[1];

  task automatic chk(bit ok, string tag, logic [31:0] act, logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s: actual %h expected %h", tag, act, exp);
    end
  endtask

  // Continuous comparison against the model, away from the active edge.
  always @(negedge clk) begin
    if (!rst && !done) begin
      chk(irq === (m_mst[0] && |(m_sts & m_en)), "R3 irq_out vs model",
          {31'd0, irq}, {31'd0, (m_mst[0] && |(m_sts & m_en))});
      if (m_rd_due) chk(rdata === m_rd, "R12 read data vs model", rdata, m_rd);
    end
  end

  task automatic wr(int a, logic [31:0] d);
    @(negedge clk);
    sel = 1; we = 1; addr = ADDR_W'(a); wdata = d;
    @(negedge clk);
    sel = 0; we = 0;
  endtask

  task automatic rd(int a, logic [31:0] exp, string tag);
    @(negedge clk);
    sel = 1; we = 0; addr = ADDR_W'(a);
    @(negedge clk);
    sel = 0;
    chk(rdata === exp, tag, rdata, exp);
  endtask

  task automatic drive(logic [31:0] v);
    @(negedge clk);
    irq_in = v;
  endtask

  task automatic irq_is(bit exp, string tag);
    chk(irq === exp, tag, {31'd0, irq}, {31'd0, exp});
  endtask

  initial begin
    repeat (3) @(negedge clk);
    rst = 0;
    // Reset state
    irq_is(0, "R1 irq low after reset");
    rd(0, 32'h0, "R1 status after reset");
    rd(2, 32'h0, "R1 enable after reset");
    rd(7, 32'h0, "R1 master after reset");
    rd(6, 32'hFFFF_FFFF, "R1 R4 vector idle");

    // Direct status write while pins are not captured
    wr(0, 32'h0000_0050);
    rd(0, 32'h0000_0050, "R8 status write allowed");
    wr(2, 32'h0000_0010);
    rd(1, 32'h0000_0010, "R2 pending is status and enable");
    rd(6, 32'd4, "R4 vector lowest pending");
    irq_is(0, "R3 irq gated by master bit 0");
    wr(7, 32'hFFFF_FFFD);
    rd(7, 32'h1, "R7 master keeps two bits");
    irq_is(1, "R3 irq asserted");

    // Acknowledge
    wr(3, 32'h0000_0010);
    rd(0, 32'h0000_0040, "R5 ack clears written bits only");
    irq_is(0, "R5 irq drops after ack");
    rd(6, 32'hFFFF_FFFF, "R4 vector none pending");
    rd(3, 32'h0, "R11 ack reads zero");

    // Enable aliases
    wr(4, 32'h0000_0F00);
    rd(2, 32'h0000_0F10, "R6 set-enable ORs");
    wr(5, 32'h0000_0010);
    rd(2, 32'h0000_0F00, "R6 clear-enable clears");
    wr(2, 32'hFFFF_FFFF);
    rd(2, 32'hFFFF_FFFF, "R6 enable direct write");
    rd(4, 32'h0, "R11 set-enable reads zero");
    rd(5, 32'h0, "R11 clear-enable reads zero");

    // Read-only addresses
    wr(1, 32'h0000_FFFF);
    wr(6, 32'h0000_0001);
    rd(1, 32'h0000_0040, "R11 pending write ignored");
    rd(6, 32'd6, "R11 vector write ignored");

    // Lock status writes once capture is on
    wr(3, 32'hFFFF_FFFF);
    wr(7, 32'h3);
    wr(0, 32'h0000_AAAA);
    rd(0, 32'h0, "R8 status write ignored with capture on");

    // Level capture
    drive(32'h0000_0008);
    drive(32'h0);
    rd(0, 32'h0000_0008, "R9 level pulse latched");
    rd(6, 32'd3, "R4 vector for level source");
    drive(32'h0000_0008);
    wr(3, 32'h0000_0008);
    rd(0, 32'h0000_0008, "R9 level re-sets while high");
    drive(32'h0);
    wr(3, 32'h0000_0008);
    rd(0, 32'h0, "R9 cleared after input low");

    // Edge capture
    drive(32'h0000_0200);
    drive(32'h0000_0200);
    wr(3, 32'h0000_0200);
    rd(0, 32'h0, "R10 no re-capture while held high");
    drive(32'h0);
    drive(32'h0000_0200);
    drive(32'h0);
    rd(0, 32'h0000_0200, "R10 edge sticky after fall");
    rd(6, 32'd9, "R4 vector for edge source");
    wr(3, 32'hFFFF_FFFF);

    // Capture disabled
    wr(7, 32'h1);
    drive(32'h0000_0404);
    drive(32'h0);
    rd(0, 32'h0, "R9 R10 no capture with bit 1 clear");

    // Priority
    wr(0, 32'h8000_0100);
    rd(6, 32'd8, "R4 lowest of two");
    wr(3, 32'h0000_0100);
    rd(6, 32'd31, "R4 top source");
    irq_is(1, "R3 irq with top source");
    wr(7, 32'h0);
    irq_is(0, "R3 irq off with master clear");
    rd(1, 32'h8000_0000, "R2 pending kept while gated");

    // Undefined addresses
    rd(9, 32'h0, "R11 undefined read");
    wr(12, 32'h0);
    rd(2, 32'hFFFF_FFFF, "R11 undefined write leaves enable");
    rd(0, 32'h8000_0000, "R11 undefined write leaves status");

    repeat (2) @(negedge clk);
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!done) begin
      done = 1;
      errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

endmodule